// File: doc/BRIEF.md
# Dual Reloading Timebase for Capture and Compare

This block holds two 16-bit up-counters that give a capture/compare unit its time reference. A single 16-bit control word sets up both counters, one byte each: the low byte for timer A and the high byte for timer B. Each byte has the same layout. A counter steps on one of three kinds of event. The first is a tick from a shared binary prescaler on the system clock. The second is a one-cycle over/underflow pulse from a neighbouring timer. The third, for timer A only, is a chosen edge of an asynchronous input pin.

When a counter steps past FFFFh it does not go to zero. It loads its own reload register and raises a one-cycle overflow strobe for the capture/compare logic. It also sets a sticky interrupt request flag, which software clears or sets by writing it. Software can also write the count and reload values directly. It must release `rst_n` in step with `clk`.

Top module: `ccu_timebase`

## Requirements
- R1: After reset the control word reads 0000h, both counts are 0000h, and both overflow strobes and both interrupt flags are low.
- R2: A control write changes only the bytes whose byte-enable is set (bit 0 low byte, bit 1 high byte). In each byte, bits 7, 5 and 4 always read 0. Bits 6, 3 and 2:0 read back as written.
- R3: With control bit 3 = 0 (prescaled mode) and select N in bits 2:0, the running counter steps exactly once in every 2^(N+3) clocks. It steps on the edges where the low N+3 bits of a free-running divider, cleared by reset, are all ones.
- R4: With control bit 6 (run) = 0, a counter holds its value whatever its event source does.
- R5: With bit 3 = 1 and select 0, a running counter steps once for each clock in which `nbr_pulse` is high.
- R6: With bit 3 = 1, timer A counts edges of `ext_in` after a two-flop synchronizer: select 1 counts rising edges, 2 counts falling edges and 3 counts both. A change of `ext_in` shows in `cnt_a` after the third rising clock edge that samples the new level.
- R7: Timer B never counts in bit-3 = 1 mode with select 1 to 7, and timer A never counts with select 4 to 7.
- R8: A step taken from FFFFh loads the timer's reload value instead of 0000h. On the same edge the timer's overflow output goes high for the cycle in which the reload value is visible.
- R9: An overflow sets the timer's interrupt flag. The flag stays set until a flag write of 0 clears it, and a flag write of 1 sets it. If an overflow and a clearing write fall on the same edge, the flag ends up set.
- R10: A count write loads `tmr_wdata` into the selected counters and takes priority over a step on the same edge, so no overflow occurs.
- R11: If both timers are given the same configuration and the same neighbour pulses from equal start values, their counts stay equal on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_be | input | 2 | Byte enables for the control write (bit 0 timer A, bit 1 timer B) |
| ctrl_wdata | input | 16 | Control write data |
| ctrl_rdata | output | 16 | Current control word |
| cnt_we | input | 2 | Count write strobe per timer (bit 0 A, bit 1 B) |
| rld_we | input | 2 | Reload write strobe per timer |
| tmr_wdata | input | 16 | Data for count and reload writes |
| irq_we | input | 2 | Interrupt flag write strobe per timer |
| irq_wdata | input | 2 | Value to write into each flag |
| nbr_pulse | input | 1 | One-cycle over/underflow pulse of the neighbouring timer |
| ext_in | input | 1 | Asynchronous external count input (timer A only) |
| cnt_a | output | 16 | Timer A count |
| cnt_b | output | 16 | Timer B count |
| ovf_a | output | 1 | Timer A overflow strobe |
| ovf_b | output | 1 | Timer B overflow strobe |
| irq_a | output | 1 | Timer A interrupt request flag |
| irq_b | output | 1 | Timer B interrupt request flag |

## Verification
The hardest case to reach from the pins is a counter wrap. From reset it would take 65536 steps, and at the slowest prescale millions of clocks. The stimulus therefore uses count writes to place the counter just below FFFFh. It then issues single neighbour pulses so that the wrap lands on a known edge. That edge is also where a clearing flag write and back-to-back wraps with a reload of FFFFh are placed. The prescaler's phase cannot be seen or set from outside. The prescale checks therefore measure windows whose length is a whole multiple of the period, in which the step count is fixed whatever the phase.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  // one byte of the shared control word
  typedef struct packed {
    logic       spare7;
    logic       run;
    logic [1:0] spare54;
    logic       ext_mode;
    logic [2:0] sel;
  } tmr_cfg_t;

  localparam logic [7:0] CFG_MASK = 8'h4F;

  // event selections when ext_mode is set
  typedef enum logic [2:0] {
    SRC_NBR  = 3'd0,
    SRC_RISE = 3'd1,
    SRC_FALL = 3'd2,
    SRC_BOTH = 3'd3
  } ext_src_e;

endpackage

// File: rtl/ccu_prescaler.sv
module ccu_prescaler #(
  parameter int MIN_LOG = 3,
  parameter int NSEL    = 8,
  localparam int PSC_W  = MIN_LOG + NSEL - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NSEL-1:0] tick_o
);

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] psc_d;

  always_comb begin
    psc_d = psc_q + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_d;
  end

  // divide-by-2^(MIN_LOG+g) tick: low bits all ones
  for (genvar g = 0; g < NSEL; g++) begin : g_tick
    assign tick_o[g] = &psc_q[MIN_LOG+g-1:0];
  end

endmodule

// File: rtl/ccu_edge_sync.sv
module ccu_edge_sync #(
  parameter int SYNC_STAGES = 2,
  localparam int SH_W = SYNC_STAGES + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);

  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[SH_W-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o =  sh_q[SH_W-2] & ~sh_q[SH_W-1];
  assign fall_o = ~sh_q[SH_W-2] &  sh_q[SH_W-1];

endmodule

// File: rtl/ccu_timer_core.sv
module ccu_timer_core #(
  parameter int CNT_W   = 16,
  parameter int SEL_W   = 3,
  parameter bit HAS_EXT = 1'b1,
  localparam int NSEL   = 2 ** SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             ext_mode_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NSEL-1:0]  psc_tick_i,
  input  logic             nbr_pulse_i,
  input  logic             ext_rise_i,
  input  logic             ext_fall_i,
  input  logic             cnt_we_i,
  input  logic             rld_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             irq_we_i,
  input  logic             irq_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             irq_o
);
  import ccu_pkg::*;

  localparam logic [CNT_W-1:0] TOP = '1;

  logic ext_r, ext_f;
  logic evt, step;
  logic [CNT_W-1:0] cnt_q, cnt_d, rld_q, rld_d;
  logic ovf_q, ovf_d, irq_q, irq_d;

  if (HAS_EXT) begin : g_ext
    assign ext_r = ext_rise_i;
    assign ext_f = ext_fall_i;
  end else begin : g_noext
    assign ext_r = ext_rise_i & 1'b0;
    assign ext_f = ext_fall_i & 1'b0;
  end

  // event source multiplexer
  always_comb begin
    evt = 1'b0;
    if (!ext_mode_i) begin
      evt = psc_tick_i[sel_i];
    end else begin
      case (sel_i)
        SRC_NBR:  evt = nbr_pulse_i;
        SRC_RISE: evt = ext_r;
        SRC_FALL: evt = ext_f;
        SRC_BOTH: evt = ext_r | ext_f;
        default:  evt = 1'b0;
      endcase
    end
    step = run_i & evt;
  end

  // next state
  always_comb begin
    cnt_d = cnt_q;
    ovf_d = 1'b0;
    if (cnt_we_i) begin
      cnt_d = wdata_i;
    end else if (step) begin
      if (cnt_q == TOP) begin
        cnt_d = rld_q;
        ovf_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
    irq_d = irq_q;
    if (irq_we_i) irq_d = irq_wdata_i;
    if (ovf_d)    irq_d = 1'b1;
    rld_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      irq_q <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rld_q <= '0;
    else if (rld_we_i) rld_q <= rld_d;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
  assign irq_o = irq_q;

endmodule

// File: rtl/ccu_timebase.sv
module ccu_timebase #(
  parameter int CNT_W   = 16,
  parameter int SEL_W   = 3,
  parameter int MIN_LOG = 3,
  localparam int NSEL   = 2 ** SEL_W,
  localparam int NTMR   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [1:0]       ctrl_be,
  input  logic [15:0]      ctrl_wdata,
  output logic [15:0]      ctrl_rdata,
  input  logic [1:0]       cnt_we,
  input  logic [1:0]       rld_we,
  input  logic [CNT_W-1:0] tmr_wdata,
  input  logic [1:0]       irq_we,
  input  logic [1:0]       irq_wdata,
  input  logic             nbr_pulse,
  input  logic             ext_in,
  output logic [CNT_W-1:0] cnt_a,
  output logic [CNT_W-1:0] cnt_b,
  output logic             ovf_a,
  output logic             ovf_b,
  output logic             irq_a,
  output logic             irq_b
);
  import ccu_pkg::*;

  tmr_cfg_t cfg_q [NTMR];
  tmr_cfg_t cfg_d [NTMR];
  logic [NSEL-1:0]  psc_tick;
  logic             ext_rise, ext_fall;
  logic [CNT_W-1:0] cnt_v [NTMR];
  logic [NTMR-1:0]  ovf_v, irq_v;

  ccu_prescaler #(.MIN_LOG(MIN_LOG), .NSEL(NSEL)) i_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (psc_tick)
  );

  ccu_edge_sync #(.SYNC_STAGES(2)) i_esync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ext_in),
    .rise_o  (ext_rise),
    .fall_o  (ext_fall)
  );

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    // control byte per timer, written under its byte enable
    always_comb begin
      cfg_d[g] = cfg_q[g];
      if (ctrl_we && ctrl_be[g]) cfg_d[g] = tmr_cfg_t'(ctrl_wdata[g*8 +: 8] & CFG_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[g] <= '0;
      else        cfg_q[g] <= cfg_d[g];
    end

    ccu_timer_core #(
      .CNT_W   (CNT_W),
      .SEL_W   (SEL_W),
      .HAS_EXT (g == 0)
    ) i_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_i       (cfg_q[g].run),
      .ext_mode_i  (cfg_q[g].ext_mode),
      .sel_i       (cfg_q[g].sel),
      .psc_tick_i  (psc_tick),
      .nbr_pulse_i (nbr_pulse),
      .ext_rise_i  (ext_rise),
      .ext_fall_i  (ext_fall),
      .cnt_we_i    (cnt_we[g]),
      .rld_we_i    (rld_we[g]),
      .wdata_i     (tmr_wdata),
      .irq_we_i    (irq_we[g]),
      .irq_wdata_i (irq_wdata[g]),
      .cnt_o       (cnt_v[g]),
      .ovf_o       (ovf_v[g]),
      .irq_o       (irq_v[g])
    );
  end

  assign ctrl_rdata = {cfg_q[1], cfg_q[0]};
  assign cnt_a = cnt_v[0];
  assign cnt_b = cnt_v[1];
  assign ovf_a = ovf_v[0];
  assign ovf_b = ovf_v[1];
  assign irq_a = irq_v[0];
  assign irq_b = irq_v[1];

endmodule

// File: rtl/ccu_timebase_chk.sv
module ccu_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_we,
  input logic [1:0]       ctrl_be,
  input logic [15:0]      ctrl_wdata,
  input logic [15:0]      ctrl_rdata,
  input logic [1:0]       cnt_we,
  input logic [1:0]       rld_we,
  input logic [CNT_W-1:0] tmr_wdata,
  input logic [1:0]       irq_we,
  input logic [1:0]       irq_wdata,
  input logic             nbr_pulse,
  input logic             ext_in,
  input logic [CNT_W-1:0] cnt_a,
  input logic [CNT_W-1:0] cnt_b,
  input logic             ovf_a,
  input logic             ovf_b,
  input logic             irq_a,
  input logic             irq_b
);

  assert_spare_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata & 16'hB0B0) == 16'h0000);

  assert_hold_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rdata[6] && !cnt_we[0]) |=> $stable(cnt_a));

  assert_hold_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rdata[14] && !cnt_we[1]) |=> $stable(cnt_b));

  assert_b_no_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata[11] && ctrl_rdata[10:8] != 3'd0 && !cnt_we[1]) |=> $stable(cnt_b));

  assert_wrap_from_top_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_a |-> $past(cnt_a) == {CNT_W{1'b1}});

  assert_wrap_from_top_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_b |-> $past(cnt_b) == {CNT_W{1'b1}});

  assert_irq_on_ovf_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_a |-> irq_a);

  assert_irq_on_ovf_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_b |-> irq_b);

  assert_cnt_write_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we[0] |=> (cnt_a == $past(tmr_wdata) && !ovf_a));

endmodule

bind ccu_timebase ccu_timebase_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_ccu_timebase.sv
`timescale 1ns/1ps
module test_ccu_timebase;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [1:0]  ctrl_be = 2'b00;
  logic [15:0] ctrl_wdata = 16'h0;
  logic [15:0] ctrl_rdata;
  logic [1:0]  cnt_we = 2'b00;
  logic [1:0]  rld_we = 2'b00;
  logic [15:0] tmr_wdata = 16'h0;
  logic [1:0]  irq_we = 2'b00;
  logic [1:0]  irq_wdata = 2'b00;
  logic        nbr_pulse = 1'b0;
  logic        ext_in = 1'b0;
  logic [15:0] cnt_a, cnt_b;
  logic        ovf_a, ovf_b, irq_a, irq_b;

  int tests = 0;
  int fails = 0;
  string phase = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ccu_timebase i_ccu_timebase (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_be(ctrl_be),
    .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata), .cnt_we(cnt_we),
    .rld_we(rld_we), .tmr_wdata(tmr_wdata), .irq_we(irq_we),
    .irq_wdata(irq_wdata), .nbr_pulse(nbr_pulse), .ext_in(ext_in),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .ovf_a(ovf_a), .ovf_b(ovf_b),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_ctrl;
  int          m_psc;
  bit          m_s1, m_s2, m_s3;
  logic [15:0] m_cnt [2];
  logic [15:0] m_rld [2];
  bit          m_ovf [2];
  bit          m_irq [2];

  always @(posedge clk or negedge rst_n) begin
    logic [7:0] cb;
    bit rise, fall, evt;
    int per;
    if (!rst_n) begin
      m_ctrl = 16'h0; m_psc = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      for (int t = 0; t < 2; t++) begin
        m_cnt[t] = 16'h0; m_rld[t] = 16'h0; m_ovf[t] = 0; m_irq[t] = 0;
      end
    end else begin
      rise = m_s2 && !m_s3;
      fall = !m_s2 && m_s3;
      for (int t = 0; t < 2; t++) begin
        cb = m_ctrl[t*8 +: 8];
        evt = 0;
        if (!cb[3]) begin
          per = 1 << (cb[2:0] + 3);
          evt = ((m_psc % per) == per - 1);
        end else begin
          case (cb[2:0])
            3'd0: evt = nbr_pulse;
            3'd1: evt = (t == 0) && rise;
            3'd2: evt = (t == 0) && fall;
            3'd3: evt = (t == 0) && (rise || fall);
            default: evt = 0;
          endcase
        end
        m_ovf[t] = 0;
        if (cnt_we[t]) m_cnt[t] = tmr_wdata;
        else if (cb[6] && evt) begin
          if (m_cnt[t] == 16'hFFFF) begin m_cnt[t] = m_rld[t]; m_ovf[t] = 1; end
          else m_cnt[t] = m_cnt[t] + 16'd1;
        end
        if (irq_we[t]) m_irq[t] = irq_wdata[t];
        if (m_ovf[t]) m_irq[t] = 1;
        if (rld_we[t]) m_rld[t] = tmr_wdata;
        if (ctrl_we && ctrl_be[t]) m_ctrl[t*8 +: 8] = ctrl_wdata[t*8 +: 8] & 8'h4F;
      end
      m_psc = (m_psc + 1) % 1024;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_in;
    end
  end

  // compare on every clock, away from the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      tests++;
      if (cnt_a !== m_cnt[0] || cnt_b !== m_cnt[1] || ovf_a !== m_ovf[0] ||
          ovf_b !== m_ovf[1] || irq_a !== m_irq[0] || irq_b !== m_irq[1] ||
          ctrl_rdata !== m_ctrl) begin
        fails++;
        $display("FAIL %s model: act a=%h b=%h ovf=%b%b irq=%b%b ctrl=%h exp a=%h b=%h ovf=%b%b irq=%b%b ctrl=%h",
                 phase, cnt_a, cnt_b, ovf_a, ovf_b, irq_a, irq_b, ctrl_rdata,
                 m_cnt[0], m_cnt[1], m_ovf[0], m_ovf[1], m_irq[0], m_irq[1], m_ctrl);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [1:0] be, input logic [15:0] d);
    ctrl_we = 1'b1; ctrl_be = be; ctrl_wdata = d;
    step(1);
    ctrl_we = 1'b0; ctrl_be = 2'b00;
  endtask

  task automatic wr_cnt(input logic [1:0] m, input logic [15:0] d);
    cnt_we = m; tmr_wdata = d;
    step(1);
    cnt_we = 2'b00;
  endtask

  task automatic wr_rld(input logic [1:0] m, input logic [15:0] d);
    rld_we = m; tmr_wdata = d;
    step(1);
    rld_we = 2'b00;
  endtask

  task automatic wr_irq(input logic [1:0] m, input logic [1:0] v);
    irq_we = m; irq_wdata = v;
    step(1);
    irq_we = 2'b00;
  endtask

  // prescale window: counter cleared and started on one edge, then n edges
  task automatic psc_window(input int tmr, input logic [2:0] sel, input int periods);
    logic [15:0] act;
    ctrl_we = 1'b1; ctrl_be = 2'b11;
    ctrl_wdata = (tmr == 0) ? {8'h00, 5'b01000, sel} : {5'b01000, sel, 8'h00};
    cnt_we = 2'b11; tmr_wdata = 16'h0;
    step(1);
    ctrl_we = 1'b0; cnt_we = 2'b00;
    step(periods * (1 << (sel + 3)));
    act = (tmr == 0) ? cnt_a : cnt_b;
    chk("R3", $sformatf("steps at select %0d", sel), act, 16'(periods));
  endtask

  task automatic ext_burst(input int n);
    for (int i = 0; i < n; i++) begin
      ext_in = 1'b1; step(3 + (i % 3));
      ext_in = 1'b0; step(4);
    end
    step(5);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int pulses;
    step(3);
    rst_n = 1'b1;
    step(1);
    phase = "R1";
    chk("R1", "ctrl after reset", ctrl_rdata, 16'h0000);
    chk("R1", "counts after reset", cnt_a | cnt_b, 16'h0000);
    chk("R1", "flags after reset", {12'h0, ovf_a, ovf_b, irq_a, irq_b}, 16'h0000);

    phase = "R2";
    wr_ctrl(2'b01, 16'hFFFF);
    chk("R2", "low byte only", ctrl_rdata, 16'h004F);
    wr_ctrl(2'b10, 16'h7F00);
    chk("R2", "high byte only", ctrl_rdata, 16'h4F4F);
    wr_ctrl(2'b01, 16'hFF30);
    chk("R2", "low byte rewrite", ctrl_rdata, 16'h4F00);
    wr_ctrl(2'b11, 16'h0000);
    chk("R2", "both bytes clear", ctrl_rdata, 16'h0000);

    phase = "R3";
    psc_window(0, 3'd0, 100);
    psc_window(0, 3'd2, 20);
    psc_window(1, 3'd5, 4);
    psc_window(1, 3'd7, 3);

    phase = "R4";
    wr_ctrl(2'b11, 16'h0808);
    wr_cnt(2'b11, 16'h0055);
    nbr_pulse = 1'b1; step(20); nbr_pulse = 1'b0;
    chk("R4", "stopped A", cnt_a, 16'h0055);
    chk("R4", "stopped B", cnt_b, 16'h0055);

    phase = "R5";
    wr_cnt(2'b11, 16'h0000);
    wr_ctrl(2'b11, 16'h4848);
    pulses = 0;
    for (int i = 0; i < 200; i++) begin
      nbr_pulse = 1'($urandom_range(0, 1));
      if (nbr_pulse) pulses++;
      step(1);
    end
    nbr_pulse = 1'b0;
    step(1);
    chk("R5", "neighbour pulses A", cnt_a, 16'(pulses));
    chk("R11", "A equals B", cnt_a, cnt_b);

    phase = "R6";
    wr_ctrl(2'b11, 16'h4949);
    wr_cnt(2'b11, 16'h0000);
    ext_burst(10);
    chk("R6", "rising edges", cnt_a, 16'd10);
    chk("R7", "B ignores ext rise", cnt_b, 16'd0);
    wr_ctrl(2'b01, 16'h004A);
    wr_cnt(2'b01, 16'h0000);
    ext_burst(7);
    chk("R6", "falling edges", cnt_a, 16'd7);
    wr_ctrl(2'b11, 16'h4B4B);
    wr_cnt(2'b01, 16'h0000);
    ext_burst(6);
    chk("R6", "both edges", cnt_a, 16'd12);
    chk("R7", "B ignores ext both", cnt_b, 16'd0);
    // latency: new level visible after third edge
    wr_ctrl(2'b01, 16'h0049);
    wr_cnt(2'b01, 16'h0000);
    ext_in = 1'b1;
    step(2);
    chk("R6", "not yet after two edges", cnt_a, 16'd0);
    step(1);
    chk("R6", "counted after third edge", cnt_a, 16'd1);
    ext_in = 1'b0; step(4);

    phase = "R7";
    wr_ctrl(2'b11, 16'h4C4D);
    wr_cnt(2'b11, 16'h0000);
    nbr_pulse = 1'b1; ext_in = 1'b1; step(6); ext_in = 1'b0; step(6);
    nbr_pulse = 1'b0;
    chk("R7", "A select 5 idle", cnt_a, 16'd0);
    chk("R7", "B select 4 idle", cnt_b, 16'd0);

    phase = "R8";
    wr_ctrl(2'b11, 16'h4848);
    wr_rld(2'b01, 16'h1234);
    wr_cnt(2'b01, 16'hFFFE);
    nbr_pulse = 1'b1;
    step(1);
    chk("R8", "reaches top", cnt_a, 16'hFFFF);
    chk("R8", "no strobe at top", {15'h0, ovf_a}, 16'h0);
    step(1);
    nbr_pulse = 1'b0;
    chk("R8", "reload on wrap", cnt_a, 16'h1234);
    chk("R8", "strobe on wrap", {15'h0, ovf_a}, 16'h1);
    chk("R9", "flag set by wrap", {15'h0, irq_a}, 16'h1);
    step(1);
    chk("R8", "strobe one cycle", {15'h0, ovf_a}, 16'h0);
    wr_rld(2'b10, 16'hFFFF);
    wr_cnt(2'b10, 16'hFFFF);
    nbr_pulse = 1'b1; step(3); nbr_pulse = 1'b0;
    chk("R8", "reload FFFF back to back", cnt_b, 16'hFFFF);
    step(2);

    phase = "R9";
    wr_irq(2'b11, 2'b00);
    chk("R9", "flag cleared", {14'h0, irq_a, irq_b}, 16'h0);
    step(5);
    chk("R9", "flag stays clear", {14'h0, irq_a, irq_b}, 16'h0);
    wr_irq(2'b01, 2'b01);
    chk("R9", "flag set by write", {15'h0, irq_a}, 16'h1);
    wr_irq(2'b01, 2'b00);
    wr_cnt(2'b01, 16'hFFFF);
    nbr_pulse = 1'b1; irq_we = 2'b01; irq_wdata = 2'b00;
    step(1);
    nbr_pulse = 1'b0; irq_we = 2'b00;
    chk("R9", "wrap beats clear", {15'h0, irq_a}, 16'h1);

    phase = "R10";
    wr_cnt(2'b01, 16'h00FF);
    nbr_pulse = 1'b1; cnt_we = 2'b01; tmr_wdata = 16'h0100;
    step(1);
    cnt_we = 2'b00; nbr_pulse = 1'b0;
    chk("R10", "write beats step", cnt_a, 16'h0100);
    wr_cnt(2'b01, 16'hFFFF);
    nbr_pulse = 1'b1; cnt_we = 2'b01; tmr_wdata = 16'h0007;
    step(1);
    cnt_we = 2'b00; nbr_pulse = 1'b0;
    chk("R10", "write at top, no wrap", {ovf_a, cnt_a[14:0]}, 16'h0007);

    phase = "R11";
    wr_cnt(2'b11, 16'hFFF0);
    wr_rld(2'b11, 16'hABCD);
    for (int i = 0; i < 60; i++) begin
      nbr_pulse = 1'($urandom_range(0, 1));
      step(1);
      chk("R11", "lockstep", cnt_a, cnt_b);
    end
    nbr_pulse = 1'b0;
    step(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule